// File: doc/BRIEF.md
# Text Console Pixel Generator

This block turns a raster scan position into pixel colours for a character console laid over a 1280x720, 60 Hz video raster. A timing generator feeds it the current X/Y position together with horizontal sync, vertical sync and blank. The block looks up the character cell under that position in a text memory, then fetches the matching glyph row from a font table. It shifts the glyph out one pixel per clock and turns each pixel into a 24-bit colour through a 16-entry palette. Each cell holds a character code and a colour attribute.

Everything on the display side runs on the pixel clock itself. The memory and font lookups take several cycles. To hide them, the block treats the incoming coordinates as eight pixels ahead of the screen and delays sync and blank by eight clocks, so colour and timing leave together. The text memory has a second port on its own clock, which a processor uses to write cells at any time.

Top module: `text_console_gen`

## Requirements
- R1: `hsync_out`, `vsync_out` and `blank_out` equal `hsync_in`, `vsync_in` and `blank_in` as sampled exactly 8 pixel clocks earlier.
- R2: The colour for scan position (x, y) uses the text cell at index (y>>4)*160 + (x>>3). A cell word holds the character code in bits [7:0] and the attribute in bits [15:8].
- R3: The glyph row for code c and line r = y[3:0] is c XOR {r, r}. Bit 7 of the row is the leftmost pixel, so pixel x uses bit 7 - x[2:0]. Coordinates advance by one per clock across a line, and every character boundary is met with no pixel dropped or repeated.
- R4: A set glyph bit selects the palette entry given by attribute bits [3:0] (foreground). A clear bit selects the entry given by attribute bits [7:4] (background).
- R5: Palette entry i (4 bits) is the 24-bit colour {i, i, ~i, ~i, i, 4'h0}: red {i,i}, green {~i,~i}, blue {i,0000}.
- R6: When `blank_out` is high, `rgb` is zero.
- R7: While `rst_n` is low, `rgb` is zero, `blank_out` is high, and both sync outputs are low.
- R8: A write to a `cpu_addr` of 7200 or above changes no displayed cell.
- R9: A cell written on `cpu_clk`, which is unrelated to the pixel clock, shows its new contents on every scan that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset, pixel domain |
| scan_x | input | 11 | Current horizontal scan position |
| scan_y | input | 10 | Current vertical scan position |
| hsync_in | input | 1 | Horizontal sync from the timing generator |
| vsync_in | input | 1 | Vertical sync from the timing generator |
| blank_in | input | 1 | High outside the visible area |
| cpu_clk | input | 1 | Write-port clock |
| cpu_we | input | 1 | Text memory write enable |
| cpu_addr | input | 13 | Text cell index to write |
| cpu_wdata | input | 16 | Cell word: attribute [15:8], code [7:0] |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |
| blank_out | output | 1 | Delayed blank |
| rgb | output | 24 | Pixel colour, red in [23:16] |

## Verification
Two situations are hard to reach from the ports.

The first is the handoff at a character boundary. There the newly fetched glyph row must replace the one still shifting out in the same clock. It is only exercised when coordinates step by one pixel through whole lines. The stimulus therefore sweeps complete 1650-clock lines over every glyph line of the first and last text rows. Each pixel is compared with a colour computed from the cell index, glyph formula and palette.

The second is a write arriving on an unrelated clock. Cells are written on a clock with a 7 ns period while the raster sits in vertical blank. Row 0 and the last row are then scanned again, once after rewritten cells and once after writes above the last valid index.

// File: rtl/text_console_gen.sv
`timescale 1ns/1ps
module text_console_gen #(
  parameter int COLS   = 160,
  parameter int ROWS   = 45,
  parameter int XW     = 11,
  parameter int YW     = 10,
  parameter int CPU_AW = 13
)(
  input  logic              pix_clk,
  input  logic              rst_n,
  input  logic [XW-1:0]     scan_x,
  input  logic [YW-1:0]     scan_y,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              blank_in,
  input  logic              cpu_clk,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [15:0]       cpu_wdata,
  output logic              hsync_out,
  output logic              vsync_out,
  output logic              blank_out,
  output logic [23:0]       rgb
);
  localparam int CELLS = COLS * ROWS;
  localparam int AW    = $clog2(CELLS);
  localparam int DLY   = 8;

  function automatic logic [7:0] font_row(input logic [7:0] code, input logic [3:0] line);
    return code ^ {line, line};
  endfunction

  function automatic logic [23:0] palette(input logic [3:0] idx);
    return {idx, idx, ~idx, ~idx, idx, 4'h0};
  endfunction

  logic [15:0] text_mem [CELLS];

  always_ff @(posedge cpu_clk)
    if (cpu_we && 32'(cpu_addr) < CELLS) text_mem[cpu_addr] <= cpu_wdata;

  wire [XW-4:0] col      = scan_x[XW-1:3];
  wire [YW-5:0] row      = scan_y[YW-1:4];
  wire          in_range = (32'(col) < COLS) && (32'(row) < ROWS);

  logic [AW-1:0] addr_q;
  logic [2:0]    xl1, xl2, xl3;
  logic [3:0]    yr1, yr2;
  logic [15:0]   cell_q;
  logic [7:0]    glyph_q, attr_q, shreg, attr_sh;
  logic [23:0]   col5, col6, col7, rgb_q;
  logic [2:0]    dl [DLY];

  always_ff @(posedge pix_clk) cell_q <= text_mem[addr_q];

  always_ff @(posedge pix_clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      xl1     <= '0;
      xl2     <= '0;
      xl3     <= '0;
      yr1     <= '0;
      yr2     <= '0;
      glyph_q <= '0;
      attr_q  <= '0;
      shreg   <= '0;
      attr_sh <= '0;
      col5    <= '0;
      col6    <= '0;
      col7    <= '0;
      rgb_q   <= '0;
      for (int i = 0; i < DLY; i++) dl[i] <= 3'b001;
    end else begin
      addr_q  <= in_range ? AW'(32'(row) * COLS + 32'(col)) : '0;
      xl1     <= scan_x[2:0];
      xl2     <= xl1;
      xl3     <= xl2;
      yr1     <= scan_y[3:0];
      yr2     <= yr1;
      glyph_q <= font_row(cell_q[7:0], yr2);
      attr_q  <= cell_q[15:8];
      if (xl3 == 3'd0) begin
        shreg   <= glyph_q;
        attr_sh <= attr_q;
      end else begin
        shreg   <= {shreg[6:0], 1'b0};
      end
      col5  <= palette(shreg[7] ? attr_sh[3:0] : attr_sh[7:4]);
      col6  <= col5;
      col7  <= col6;
      rgb_q <= dl[DLY-2][0] ? '0 : col7;
      dl[0] <= {hsync_in, vsync_in, blank_in};
      for (int i = 1; i < DLY; i++) dl[i] <= dl[i-1];
    end
  end

  assign hsync_out = dl[DLY-1][2];
  assign vsync_out = dl[DLY-1][1];
  assign blank_out = dl[DLY-1][0];
  assign rgb       = rgb_q;
endmodule

// File: rtl/text_console_gen_checks.sv
`timescale 1ns/1ps
module text_console_gen_checks (
  input logic        pix_clk,
  input logic        rst_n,
  input logic        hsync_in,
  input logic        vsync_in,
  input logic        blank_in,
  input logic        hsync_out,
  input logic        vsync_out,
  input logic        blank_out,
  input logic [23:0] rgb,
  input logic [2:0]  xl3,
  input logic [7:0]  shreg,
  input logic [7:0]  glyph_q
);
  logic [3:0] run_cnt;

  always_ff @(posedge pix_clk)
    if (!rst_n) run_cnt <= '0;
    else if (run_cnt != 4'd15) run_cnt <= run_cnt + 4'd1;

  p_sync_delay_r1: assert property (@(posedge pix_clk) disable iff (!rst_n)
    run_cnt >= 4'd8 |-> (hsync_out == $past(hsync_in, 8) &&
                         vsync_out == $past(vsync_in, 8) &&
                         blank_out == $past(blank_in, 8)));

  p_blank_black_r6: assert property (@(posedge pix_clk) disable iff (!rst_n)
    blank_out |-> rgb == 24'h0);

  p_reset_state_r7: assert property (@(posedge pix_clk)
    !rst_n |=> (rgb == 24'h0 && blank_out && !hsync_out && !vsync_out));

  p_glyph_shift_r3: assert property (@(posedge pix_clk) disable iff (!rst_n)
    xl3 != 3'd0 |=> shreg == 8'($past(shreg) << 1));

  p_glyph_load_r3: assert property (@(posedge pix_clk) disable iff (!rst_n)
    xl3 == 3'd0 |=> shreg == $past(glyph_q));
endmodule

bind text_console_gen text_console_gen_checks u_checks (
  .pix_clk  (pix_clk),
  .rst_n    (rst_n),
  .hsync_in (hsync_in),
  .vsync_in (vsync_in),
  .blank_in (blank_in),
  .hsync_out(hsync_out),
  .vsync_out(vsync_out),
  .blank_out(blank_out),
  .rgb      (rgb),
  .xl3      (xl3),
  .shreg    (shreg),
  .glyph_q  (glyph_q)
);

// File: tb/text_console_gen_bench.sv
`timescale 1ns/1ps
module text_console_gen_bench;
  logic        pix_clk = 1'b0;
  logic        cpu_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] scan_x = '0;
  logic [9:0]  scan_y = '0;
  logic        hsync_in = 1'b0, vsync_in = 1'b0, blank_in = 1'b1;
  logic        cpu_we = 1'b0;
  logic [12:0] cpu_addr = '0;
  logic [15:0] cpu_wdata = '0;
  logic        hsync_out, vsync_out, blank_out;
  logic [23:0] rgb;

  always #2.5 pix_clk = ~pix_clk;
  always #3.5 cpu_clk = ~cpu_clk;

  text_console_gen u_text_console_gen (
    .pix_clk(pix_clk), .rst_n(rst_n), .scan_x(scan_x), .scan_y(scan_y),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .blank_in(blank_in),
    .cpu_clk(cpu_clk), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .hsync_out(hsync_out), .vsync_out(vsync_out), .blank_out(blank_out), .rgb(rgb)
  );

  int checks = 0;
  int fails  = 0;
  logic [15:0] model [7200];
  logic [26:0] ring [8];
  int rp = 0;
  string tag = "R2 R3 R4 R5";

  function automatic logic [26:0] expect_px(input int x, input int y);
    logic hs, vs, bl, bitv;
    logic [15:0] c;
    logic [7:0] g;
    logic [3:0] yl, ai;
    logic [23:0] col;
    hs  = (x >= 1390 && x < 1430);
    vs  = (y >= 725 && y < 730);
    bl  = (x >= 1280 || y >= 720);
    col = '0;
    if (!bl) begin
      c    = model[(y / 16) * 160 + x / 8];
      yl   = 4'(y);
      g    = c[7:0] ^ {yl, yl};
      bitv = g[7 - (x % 8)];
      ai   = bitv ? c[11:8] : c[15:12];
      col  = {ai, ai, ~ai, ~ai, ai, 4'h0};
    end
    return {hs, vs, bl, col};
  endfunction

  task automatic pix(input int x, input int y);
    logic [26:0] e, n;
    @(negedge pix_clk);
    e = ring[rp];
    checks++;
    if ({hsync_out, vsync_out, blank_out} !== e[26:24]) begin
      fails++;
      $display("FAIL R1 sync/blank actual=%b expected=%b", {hsync_out, vsync_out, blank_out}, e[26:24]);
    end
    checks++;
    if (rgb !== e[23:0]) begin
      fails++;
      if (e[24]) $display("FAIL R6 blanked rgb actual=%h expected=%h", rgb, e[23:0]);
      else       $display("FAIL %s rgb actual=%h expected=%h", tag, rgb, e[23:0]);
    end
    n = expect_px(x, y);
    scan_x   = 11'(x);
    scan_y   = 10'(y);
    hsync_in = n[26];
    vsync_in = n[25];
    blank_in = n[24];
    ring[rp] = n;
    rp = (rp + 1) % 8;
  endtask

  task automatic scan_line(input int y);
    for (int x = 0; x < 1650; x++) pix(x, y);
  endtask

  task automatic cpu_write(input int a, input logic [15:0] d);
    @(negedge cpu_clk);
    cpu_we    = 1'b1;
    cpu_addr  = 13'(a);
    cpu_wdata = d;
    if (a < 7200) model[a] = d;
  endtask

  initial begin
    repeat (150000) @(posedge pix_clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) ring[i] = {3'b001, 24'h0};
    for (int i = 0; i < 7200; i++) model[i] = '0;
    repeat (4) @(negedge pix_clk);
    checks++;
    if (rgb !== 24'h0 || blank_out !== 1'b1 || hsync_out !== 1'b0 || vsync_out !== 1'b0) begin
      fails++;
      $display("FAIL R7 reset outputs actual=%h/%b%b%b expected=000000/001", rgb, hsync_out, vsync_out, blank_out);
    end
    @(negedge pix_clk);
    rst_n = 1'b1;

    fork
      begin
        for (int i = 0; i < 7200; i++)
          cpu_write(i, {8'(i * 37 + 5), 8'(i * 13) ^ 8'(i >> 5)});
        @(negedge cpu_clk) cpu_we = 1'b0;
      end
      repeat (8) scan_line(735);
    join

    tag = "R2 R3 R4 R5";
    for (int y = 0; y < 18; y++) scan_line(y);
    for (int y = 704; y < 722; y++) scan_line(y);
    tag = "R6";
    scan_line(727);

    fork
      begin
        for (int i = 0; i < 160; i++) cpu_write(i, {8'(i * 91 + 3), 8'(255 - i)});
        cpu_write(7200, 16'hFFFF);
        cpu_write(8191, 16'hA5A5);
        cpu_write(7300, 16'h1234);
        @(negedge cpu_clk) cpu_we = 1'b0;
      end
      scan_line(740);
    join

    tag = "R9";
    for (int y = 0; y < 4; y++) scan_line(y);
    tag = "R8";
    scan_line(719);
    scan_line(0);
    scan_line(745);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule